// File: doc/BRIEF.md
# Atomic Compare-and-Swap Memory Target

This block is a small memory target behind a valid/ready request channel and a valid/ready response channel. It holds a byte-addressed array that covers a fixed address window. It serves plain reads and writes, an unconditional swap, and a compare-and-swap. A swap returns the previous contents and stores the new data. A compare-and-swap carries its compare value with the request and stores the new data only when memory matches that value. Accesses of 1, 2, 4 or 8 bytes may start at any byte address, provided the whole access stays inside the window.

The block also accepts requests that need no memory work. A request that another agent has already answered is discarded, and so is a clean-eviction hint. Invalidate and clean maintenance requests are acknowledged and leave memory unchanged. A malformed request sets a sticky error flag, gets no reply and changes nothing.

Only one transaction is in flight at a time. The block accepts a request when no response is waiting. Any read, compare and write happen in the cycle of acceptance, so a swap is indivisible. The reply appears on the response port in the next cycle.

Top module: `cas_mem_target`

## Requirements
- R1: While reset is high and in the cycle after it, `resp_valid` and `err_o` are 0. With no response pending, `req_ready` is 1.
- R2: Read (command code 0) returns the `2**req_size` bytes that start at `req_addr`, with the lowest address in bits 7:0 and the upper bytes zero. Any start alignment is allowed, including an access that crosses an 8-byte boundary or ends at the last byte of the window.
- R3: Write (code 1) stores the low `2**req_size` bytes of `req_wdata` and leaves all other bytes unchanged. Its response carries zero data.
- R4: Swap (code 2) returns the old contents of the addressed bytes and replaces them with `req_wdata`.
- R5: Compare-and-swap (code 3) with size code 2 (4 bytes) or 3 (8 bytes) compares only the low access-size bytes of `req_cmp` with memory. On a match it writes `req_wdata` and returns the old contents.
- R6: A compare-and-swap whose compare value differs from memory leaves memory unchanged and still returns the old contents.
- R7: A compare-and-swap with size code 0 or 1 sets `err_o`, sends no response and leaves memory unchanged.
- R8: A swap or compare-and-swap with `req_ifetch` set sets `err_o`, sends no response and leaves memory unchanged.
- R9: A request with `req_serviced` set is discarded whatever its command: no response, no memory change and no error.
- R10: A clean-eviction hint (code 4) is discarded without response or error, even when its address lies outside the window.
- R11: Invalidate (code 5) and clean (code 6) leave memory unchanged. When a reply is requested, they answer with zero data.
- R12: A response is sent only when `req_need_resp` was set. `resp_valid` and `resp_data` hold until `resp_ready`. `req_ready` stays low while a response is pending.
- R13: An unknown command (code 7), or an access that does not lie wholly within the window, sets `err_o`, sends no response and changes no memory. `err_o` then stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with `req_valid` |
| req_cmd | input | 3 | Command code |
| req_addr | input | ADDR_W | Byte address of the first accessed byte |
| req_size | input | SIZE_W | log2 of the access length in bytes |
| req_wdata | input | 8*DATA_BYTES | Store or swap data, low bytes used |
| req_cmp | input | 8*DATA_BYTES | Compare value for compare-and-swap |
| req_need_resp | input | 1 | Requester wants a reply |
| req_serviced | input | 1 | Request already answered elsewhere |
| req_ifetch | input | 1 | Request marked as an instruction fetch |
| resp_valid | output | 1 | Response present |
| resp_ready | input | 1 | Response taken |
| resp_data | output | 8*DATA_BYTES | Old memory contents, or zero |
| err_o | output | 1 | Sticky error flag |

## Verification
The data path is exercised with aligned 8-byte accesses, narrow accesses at odd offsets and a 4-byte access that straddles two rows. Together these separate a lane-rotation fault from a row-selection fault on both the read and the write side. Compare-and-swap is run with a matching value, with a mismatching value, and with a 4-byte compare whose upper compare bytes hold garbage. These cases show whether the write is gated by the compare and whether the compare mask follows the size. The discard and error paths are each followed by a read-back, which shows that the rejected request left memory untouched. A response held back by a stalled `resp_ready` shows whether the reply stays stable and whether new requests are blocked.

// File: rtl/cmt_pkg.sv
package cmt_pkg;

  // Command codes seen on req_cmd
  typedef enum logic [2:0] {
    CMD_READ  = 3'd0,
    CMD_WRITE = 3'd1,
    CMD_SWAP  = 3'd2,
    CMD_CSWAP = 3'd3,
    CMD_EVICT = 3'd4,
    CMD_INVAL = 3'd5,
    CMD_CLEAN = 3'd6,
    CMD_RSVD  = 3'd7
  } cmd_e;

  // Internal action chosen for an accepted request
  typedef enum logic [2:0] {
    ACT_DROP  = 3'd0,
    ACT_READ  = 3'd1,
    ACT_WRITE = 3'd2,
    ACT_SWAP  = 3'd3,
    ACT_CSWAP = 3'd4,
    ACT_MAINT = 3'd5,
    ACT_ERROR = 3'd6
  } act_e;

endpackage

// File: rtl/cmt_decode.sv
module cmt_decode
  import cmt_pkg::*;
#(
  parameter int                ADDR_W     = 32,
  parameter logic [ADDR_W-1:0] WIN_BASE   = 'h1000,
  parameter int                WIN_BYTES  = 256,
  parameter int                DATA_BYTES = 8,
  localparam int LANE_W = $clog2(DATA_BYTES),
  localparam int SIZE_W = $clog2(LANE_W + 1),
  localparam int ROWS   = WIN_BYTES / DATA_BYTES,
  localparam int ROW_W  = $clog2(ROWS)
) (
  input  logic [2:0]        cmd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [SIZE_W-1:0] size,
  input  logic              serviced,
  input  logic              ifetch,
  output act_e              act,
  output logic [LANE_W:0]   nbytes,
  output logic [LANE_W-1:0] off,
  output logic [ROW_W-1:0]  row
);

  logic [ADDR_W-1:0] rel;
  logic [ADDR_W:0]   span_end;
  logic              oversize;
  logic              in_win;
  logic              cas_size_ok;
  logic              ok;

  assign rel      = addr - WIN_BASE;
  assign oversize = (int'(size) > LANE_W);
  assign nbytes   = oversize ? '0 : ((LANE_W+1)'(1) << size);
  assign span_end = {1'b0, rel} + {{(ADDR_W-LANE_W){1'b0}}, nbytes};
  assign in_win   = (addr >= WIN_BASE) && (span_end <= (ADDR_W+1)'(WIN_BYTES));
  assign ok       = in_win && !oversize;
  assign off      = rel[LANE_W-1:0];
  assign row      = rel[LANE_W +: ROW_W];
  assign cas_size_ok = (nbytes == (LANE_W+1)'(4)) || (nbytes == (LANE_W+1)'(8));

  always_comb begin
    act = ACT_DROP;
    if (!serviced) begin
      case (cmd_e'(cmd))
        CMD_EVICT: act = ACT_DROP;
        CMD_READ:  act = ok ? ACT_READ : ACT_ERROR;
        CMD_WRITE: act = ok ? ACT_WRITE : ACT_ERROR;
        CMD_SWAP:  act = (ok && !ifetch) ? ACT_SWAP : ACT_ERROR;
        CMD_CSWAP: act = (ok && !ifetch && cas_size_ok) ? ACT_CSWAP : ACT_ERROR;
        CMD_INVAL,
        CMD_CLEAN: act = ok ? ACT_MAINT : ACT_ERROR;
        default:   act = ACT_ERROR;
      endcase
    end
  end

endmodule

// File: rtl/cmt_lane_ram.sv
module cmt_lane_ram #(
  parameter int ROWS  = 32,
  parameter int ROW_W = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [ROW_W-1:0] addr,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata
);

  logic [7:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  // Asynchronous read: old value is visible in the cycle it is replaced
  assign rdata = mem[addr];

endmodule

// File: rtl/cmt_resp_reg.sv
module cmt_resp_reg #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              resp_ready,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_data
);

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= 1'b0;
      resp_data  <= '0;
    end else if (load) begin
      resp_valid <= 1'b1;
      resp_data  <= load_data;
    end else if (resp_valid && resp_ready) begin
      resp_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/cas_mem_target.sv
module cas_mem_target
  import cmt_pkg::*;
#(
  parameter int                ADDR_W     = 32,
  parameter logic [ADDR_W-1:0] WIN_BASE   = 'h1000,
  parameter int                WIN_BYTES  = 256,
  parameter int                DATA_BYTES = 8,
  localparam int LANE_W = $clog2(DATA_BYTES),
  localparam int SIZE_W = $clog2(LANE_W + 1),
  localparam int DATA_W = 8 * DATA_BYTES,
  localparam int ROWS   = WIN_BYTES / DATA_BYTES,
  localparam int ROW_W  = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_cmd,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SIZE_W-1:0] req_size,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] req_cmp,
  input  logic              req_need_resp,
  input  logic              req_serviced,
  input  logic              req_ifetch,
  output logic              resp_valid,
  input  logic              resp_ready,
  output logic [DATA_W-1:0] resp_data,
  output logic              err_o
);

  act_e              act;
  logic [LANE_W:0]   nbytes;
  logic [LANE_W-1:0] off;
  logic [ROW_W-1:0]  row;
  logic              accept;
  logic              do_write;
  logic              cas_hit;
  logic              resp_load;
  logic [DATA_W-1:0] old_data;
  logic [DATA_W-1:0] byte_mask;
  logic [DATA_W-1:0] resp_payload;
  logic [7:0]        rd_lane [DATA_BYTES];

  assign req_ready = !resp_valid;
  assign accept    = req_valid && req_ready;

  cmt_decode #(
    .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE),
    .WIN_BYTES(WIN_BYTES), .DATA_BYTES(DATA_BYTES)
  ) u_dec (
    .cmd(req_cmd), .addr(req_addr), .size(req_size),
    .serviced(req_serviced), .ifetch(req_ifetch),
    .act(act), .nbytes(nbytes), .off(off), .row(row)
  );

  // Byte lanes: lane j holds every byte whose window offset is j mod DATA_BYTES
  for (genvar j = 0; j < DATA_BYTES; j++) begin : g_lane
    localparam logic [LANE_W-1:0] JIDX = LANE_W'(j);
    logic [LANE_W-1:0] pos;
    logic [ROW_W-1:0]  lrow;
    logic              used;
    assign pos  = JIDX - off;
    assign lrow = (JIDX < off) ? row + ROW_W'(1) : row;
    assign used = ({1'b0, pos} < nbytes);
    cmt_lane_ram #(.ROWS(ROWS), .ROW_W(ROW_W)) u_ram (
      .clk(clk),
      .we(do_write && used),
      .addr(lrow),
      .wdata(req_wdata[8*pos +: 8]),
      .rdata(rd_lane[j])
    );
  end

  // Rotate lanes back into access order and zero the unused upper bytes
  for (genvar k = 0; k < DATA_BYTES; k++) begin : g_byte
    logic [LANE_W-1:0] src;
    logic              live;
    assign src  = off + LANE_W'(k);
    assign live = ({1'b0, LANE_W'(k)} < nbytes);
    assign old_data[8*k +: 8]  = live ? rd_lane[src] : 8'h00;
    assign byte_mask[8*k +: 8] = live ? 8'hFF : 8'h00;
  end

  assign cas_hit  = ((old_data ^ req_cmp) & byte_mask) == '0;
  assign do_write = accept && ((act == ACT_WRITE) || (act == ACT_SWAP) ||
                               ((act == ACT_CSWAP) && cas_hit));

  assign resp_load = accept && req_need_resp &&
                     ((act == ACT_READ) || (act == ACT_WRITE) || (act == ACT_SWAP) ||
                      (act == ACT_CSWAP) || (act == ACT_MAINT));
  assign resp_payload = ((act == ACT_READ) || (act == ACT_SWAP) || (act == ACT_CSWAP))
                        ? old_data : '0;

  cmt_resp_reg #(.DATA_W(DATA_W)) u_resp (
    .clk(clk), .rst(rst),
    .load(resp_load), .load_data(resp_payload),
    .resp_ready(resp_ready),
    .resp_valid(resp_valid), .resp_data(resp_data)
  );

  always_ff @(posedge clk) begin
    if (rst)                          err_o <= 1'b0;
    else if (accept && act == ACT_ERROR) err_o <= 1'b1;
  end

endmodule

// File: rtl/cmt_checker.sv
module cmt_checker #(
  parameter int ADDR_W     = 32,
  parameter int DATA_BYTES = 8,
  localparam int LANE_W = $clog2(DATA_BYTES),
  localparam int SIZE_W = $clog2(LANE_W + 1),
  localparam int DATA_W = 8 * DATA_BYTES
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [2:0]        req_cmd,
  input logic [SIZE_W-1:0] req_size,
  input logic              req_need_resp,
  input logic              req_serviced,
  input logic              req_ifetch,
  input logic              resp_valid,
  input logic              resp_ready,
  input logic [DATA_W-1:0] resp_data,
  input logic              err_o
);

  logic acc;
  logic cas_bad_size;
  assign acc = req_valid && req_ready;
  assign cas_bad_size = (int'(req_size) != 2) && (int'(req_size) != 3);

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (!resp_valid && !err_o));

  // R12
  resp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_data)));

  // R12
  busy_block_chk: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> !req_ready);

  // R12
  unasked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && !req_need_resp) |=> !resp_valid);

  // R13
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err_o |=> err_o);

  // R13
  unknown_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && !req_serviced && req_cmd == 3'd7) |=> (err_o && !resp_valid));

  // R9
  serviced_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && req_serviced) |=> (!resp_valid && $stable(err_o)));

  // R10
  evict_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && req_cmd == 3'd4) |=> (!resp_valid && $stable(err_o)));

  // R8
  ifetch_swap_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && !req_serviced && req_ifetch && (req_cmd == 3'd2 || req_cmd == 3'd3))
      |=> (err_o && !resp_valid));

  // R7
  cas_size_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && !req_serviced && req_cmd == 3'd3 && cas_bad_size) |=> (err_o && !resp_valid));

endmodule

bind cas_mem_target cmt_checker #(.ADDR_W(ADDR_W), .DATA_BYTES(DATA_BYTES)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_cmd(req_cmd), .req_size(req_size), .req_need_resp(req_need_resp),
  .req_serviced(req_serviced), .req_ifetch(req_ifetch),
  .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_data(resp_data),
  .err_o(err_o)
);

// File: tb/tb_cas_mem_target.sv
module tb_cas_mem_target;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_cmd = '0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [63:0] req_wdata = '0;
  logic [63:0] req_cmp = '0;
  logic        req_need_resp = 1'b0;
  logic        req_serviced = 1'b0;
  logic        req_ifetch = 1'b0;
  logic        resp_valid;
  logic        resp_ready = 1'b1;
  logic [63:0] resp_data;
  logic        err_o;

  int tests = 0;
  int fails = 0;

  cas_mem_target dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_addr(req_addr), .req_size(req_size),
    .req_wdata(req_wdata), .req_cmp(req_cmp), .req_need_resp(req_need_resp),
    .req_serviced(req_serviced), .req_ifetch(req_ifetch),
    .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_data(resp_data),
    .err_o(err_o)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  // Drive one request; report whether a response appeared the cycle after acceptance
  task automatic xact(input logic [2:0] c, input logic [31:0] a, input logic [1:0] sz,
                      input logic [63:0] wd, input logic [63:0] cmp, input bit need,
                      input bit serv, input bit ifet, output bit got, output logic [63:0] d);
    @(negedge clk);
    req_cmd = c; req_addr = a; req_size = sz; req_wdata = wd; req_cmp = cmp;
    req_need_resp = need; req_serviced = serv; req_ifetch = ifet; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    got = resp_valid;
    d = resp_data;
  endtask

  task automatic wr(input logic [31:0] a, input logic [1:0] sz, input logic [63:0] wd);
    bit g; logic [63:0] d;
    xact(3'd1, a, sz, wd, '0, 1'b0, 1'b0, 1'b0, g, d);
  endtask

  task automatic rd(input logic [31:0] a, input logic [1:0] sz, output logic [63:0] d);
    bit g;
    xact(3'd0, a, sz, '0, '0, 1'b1, 1'b0, 1'b0, g, d);
    if (!g) d = 'x;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 req_ready", {63'd0, req_ready}, 64'd1);
    chk("R1 resp_valid", {63'd0, resp_valid}, 64'd0);
    chk("R1 err_o", {63'd0, err_o}, 64'd0);
  endtask

  task automatic t_read_write();
    logic [63:0] d; bit g;
    xact(3'd1, 32'h1000, 2'd3, 64'h8877665544332211, '0, 1'b1, 1'b0, 1'b0, g, d);
    chk("R3 write resp valid", {63'd0, g}, 64'd1);
    chk("R3 write resp data", d, 64'd0);
    rd(32'h1000, 2'd3, d); chk("R2 read 8B aligned", d, 64'h8877665544332211);
    rd(32'h1003, 2'd0, d); chk("R2 read 1B odd", d, 64'h44);
    wr(32'h1005, 2'd1, 64'hFFFF_FFFF_FFFF_BEEF);
    rd(32'h1000, 2'd3, d); chk("R3 2B write merge", d, 64'h88BEEF5544332211);
    wr(32'h1008, 2'd3, 64'd0);
    wr(32'h1010, 2'd3, 64'd0);
    wr(32'h100E, 2'd2, 64'h1234_5678_DDCC_BBAA);
    rd(32'h100E, 2'd2, d); chk("R2 straddle read", d, 64'hDDCCBBAA);
    rd(32'h1008, 2'd3, d); chk("R3 straddle low row", d, 64'hBBAA000000000000);
    rd(32'h1010, 2'd3, d); chk("R3 straddle high row", d, 64'h000000000000DDCC);
    wr(32'h10F8, 2'd3, 64'h0102030405060708);
    rd(32'h10F8, 2'd3, d); chk("R2 window top", d, 64'h0102030405060708);
  endtask

  task automatic t_swap();
    logic [63:0] d; bit g;
    wr(32'h1020, 2'd3, 64'd0);
    wr(32'h1020, 2'd2, 64'h11223344);
    xact(3'd2, 32'h1020, 2'd2, 64'hAABBCCDD, '0, 1'b1, 1'b0, 1'b0, g, d);
    chk("R4 swap returns old", d, 64'h11223344);
    rd(32'h1020, 2'd2, d); chk("R4 swap stored new", d, 64'hAABBCCDD);
  endtask

  task automatic t_cswap();
    logic [63:0] d; bit g;
    wr(32'h1040, 2'd3, 64'hCAFEF00D12345678);
    xact(3'd3, 32'h1040, 2'd3, 64'd1, 64'hCAFEF00D12345678, 1'b1, 1'b0, 1'b0, g, d);
    chk("R5 cas8 hit returns old", d, 64'hCAFEF00D12345678);
    rd(32'h1040, 2'd3, d); chk("R5 cas8 hit stored", d, 64'd1);
    xact(3'd3, 32'h1040, 2'd3, 64'h99, 64'd2, 1'b1, 1'b0, 1'b0, g, d);
    chk("R6 cas miss returns old", d, 64'd1);
    rd(32'h1040, 2'd3, d); chk("R6 cas miss unchanged", d, 64'd1);
    xact(3'd3, 32'h1044, 2'd2, 64'h5A5A5A5A, 64'hFFFFFFFF_00000000, 1'b1, 1'b0, 1'b0, g, d);
    chk("R5 cas4 returns old", d, 64'd0);
    rd(32'h1040, 2'd3, d); chk("R5 cas4 masked compare", d, 64'h5A5A5A5A00000001);
  endtask

  task automatic t_cas_badsize();
    logic [63:0] d; bit g;
    do_reset();
    xact(3'd3, 32'h1040, 2'd1, 64'hFFFF, 64'd1, 1'b1, 1'b0, 1'b0, g, d);
    chk("R7 no response", {63'd0, g}, 64'd0);
    chk("R7 err set", {63'd0, err_o}, 64'd1);
    rd(32'h1040, 2'd3, d); chk("R7 memory unchanged", d, 64'h5A5A5A5A00000001);
  endtask

  task automatic t_ifetch();
    logic [63:0] d; bit g;
    do_reset();
    xact(3'd2, 32'h1020, 2'd2, 64'h1, '0, 1'b1, 1'b0, 1'b1, g, d);
    chk("R8 no response", {63'd0, g}, 64'd0);
    chk("R8 err set", {63'd0, err_o}, 64'd1);
    rd(32'h1020, 2'd2, d); chk("R8 memory unchanged", d, 64'hAABBCCDD);
  endtask

  task automatic t_serviced();
    logic [63:0] d; bit g;
    do_reset();
    xact(3'd1, 32'h1000, 2'd3, 64'd0, '0, 1'b1, 1'b1, 1'b0, g, d);
    chk("R9 no response", {63'd0, g}, 64'd0);
    xact(3'd7, 32'h1000, 2'd3, 64'd0, '0, 1'b1, 1'b1, 1'b0, g, d);
    chk("R9 no error", {63'd0, err_o}, 64'd0);
    rd(32'h1000, 2'd3, d); chk("R9 memory unchanged", d, 64'h88BEEF5544332211);
  endtask

  task automatic t_evict();
    logic [63:0] d; bit g;
    do_reset();
    xact(3'd4, 32'h1000, 2'd3, 64'd0, '0, 1'b1, 1'b0, 1'b0, g, d);
    chk("R10 no response", {63'd0, g}, 64'd0);
    xact(3'd4, 32'h2000, 2'd3, 64'd0, '0, 1'b1, 1'b0, 1'b0, g, d);
    chk("R10 no error out of window", {63'd0, err_o}, 64'd0);
  endtask

  task automatic t_maint();
    logic [63:0] d; bit g;
    do_reset();
    xact(3'd5, 32'h1000, 2'd3, 64'hFF, '0, 1'b1, 1'b0, 1'b0, g, d);
    chk("R11 inval response", {63'd0, g}, 64'd1);
    chk("R11 inval data zero", d, 64'd0);
    xact(3'd6, 32'h1000, 2'd3, 64'hFF, '0, 1'b0, 1'b0, 1'b0, g, d);
    chk("R11 clean unasked no response", {63'd0, g}, 64'd0);
    rd(32'h1000, 2'd3, d); chk("R11 memory unchanged", d, 64'h88BEEF5544332211);
    chk("R11 no error", {63'd0, err_o}, 64'd0);
  endtask

  task automatic t_resp_flow();
    logic [63:0] d; logic [63:0] first; bit g;
    xact(3'd1, 32'h1080, 2'd3, 64'h0F0E0D0C0B0A0908, '0, 1'b0, 1'b0, 1'b0, g, d);
    chk("R12 unasked write no response", {63'd0, g}, 64'd0);
    resp_ready = 1'b0;
    xact(3'd0, 32'h1080, 2'd3, '0, '0, 1'b1, 1'b0, 1'b0, g, first);
    chk("R12 stalled response data", first, 64'h0F0E0D0C0B0A0908);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R12 response held", {63'd0, resp_valid}, 64'd1);
      chk("R12 data stable", resp_data, first);
      chk("R12 ready low while pending", {63'd0, req_ready}, 64'd0);
    end
    resp_ready = 1'b1;
    @(negedge clk);
    chk("R12 response released", {63'd0, resp_valid}, 64'd0);
    chk("R12 ready restored", {63'd0, req_ready}, 64'd1);
  endtask

  task automatic t_bad();
    logic [63:0] d; bit g;
    do_reset();
    xact(3'd0, 32'h10FC, 2'd3, '0, '0, 1'b1, 1'b0, 1'b0, g, d);
    chk("R13 past window end no response", {63'd0, g}, 64'd0);
    chk("R13 past window end err", {63'd0, err_o}, 64'd1);
    rd(32'h1000, 2'd0, d);
    chk("R13 err sticky", {63'd0, err_o}, 64'd1);
    do_reset();
    xact(3'd1, 32'h0FFF, 2'd0, 64'h77, '0, 1'b1, 1'b0, 1'b0, g, d);
    chk("R13 below window err", {63'd0, err_o}, 64'd1);
    rd(32'h1000, 2'd3, d); chk("R13 below window no write", d, 64'h88BEEF5544332211);
    do_reset();
    xact(3'd7, 32'h1000, 2'd3, 64'd0, '0, 1'b1, 1'b0, 1'b0, g, d);
    chk("R13 unknown cmd no response", {63'd0, g}, 64'd0);
    chk("R13 unknown cmd err", {63'd0, err_o}, 64'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    do_reset();
    t_reset();
    t_read_write();
    t_swap();
    t_cswap();
    t_cas_badsize();
    t_ifetch();
    t_serviced();
    t_evict();
    t_maint();
    t_resp_flow();
    t_bad();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule